// File: doc/BRIEF.md
# Oldest Squash Redirect Arbiter

This block sits in the execute stage of one hardware thread. Each cycle it looks at the group of instructions that execute together, in program order from lane 0 upward. It decides which of them, if any, forces a pipeline squash and a fetch redirect. A lane can raise a squash in two ways. The first is a resolved branch that turns out to be mispredicted. The second is a memory-order violation, reported by the load/store logic together with the sequence number of the offending younger instruction.

Squash state never carries across cycles. At the start of every execute group the arbiter has nothing pending. It then walks the lanes. A lane can claim the squash only if nothing is pending yet, or if its own sequence number is strictly older (smaller) than the pending one. On a claiming lane, a mispredict is tested first. A load that has not executed yet cannot claim a mispredict. A memory-order violation is considered only when no mispredict is taken on that lane. A violation squashes from the violator's sequence number, not from the executing lane's, and the violating pair is reported to the instruction queue. A violation on a lane that may not claim is only counted.

The chosen squash, the instruction-queue notification and the per-group statistics counts are registered. They are presented one cycle after the execute group. Sequence numbers are compared unsigned, and wraparound within one group is not supported.

Top module: `squash_pick`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: The outputs in cycle N+1 depend only on the lane inputs of cycle N, because pending state is cleared for each group. When no squash is chosen, redir_valid_o, redir_seq_o, redir_cause_o, both queue-notify sequence outputs and iq_viol_valid_o are all zero.
- R3: A valid lane with a mispredict that may claim gives a redirect with redir_seq_o equal to that lane's sequence number and redir_cause_o = 0 (branch).
- R4: A lane whose load flag is 1 and executed flag is 0 cannot claim a mispredict. Its mispredict is neither acted upon nor counted, but a violation on the same lane is still considered.
- R5: When one claiming lane has both a mispredict and a violation, the mispredict wins. The result is cause 0 and no queue notification.
- R6: A claiming violation gives a redirect with redir_seq_o equal to the violator sequence number and redir_cause_o = 1 (memory order). It also sets iq_viol_valid_o with iq_viol_inst_seq_o equal to the lane's own sequence number and iq_viol_src_seq_o equal to the violator's.
- R7: A later lane replaces the pending squash only if its sequence number is strictly smaller than the pending sequence number. An equal or larger number does not replace it. Comparison is unsigned.
- R8: A violation on a valid lane that may not claim adds one to stat_viol_ignored_o and changes nothing else.
- R9: Each mispredict that is acted upon is counted in stat_misp_taken_o when its predicted-taken flag is 1, and in stat_misp_ntaken_o when it is 0. This holds even if a later, older lane replaces it.
- R10: Lanes whose valid bit is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid_i | input | LANES | Lane holds an executed instruction |
| lane_seq_i | input | LANES*SEQ_W | Lane sequence number |
| lane_misp_i | input | LANES | Branch resolved as mispredicted |
| lane_pred_taken_i | input | LANES | Branch had been predicted taken |
| lane_load_i | input | LANES | Instruction is a load |
| lane_done_i | input | LANES | Instruction has executed |
| lane_viol_i | input | LANES | Memory-order violation reported on this lane |
| lane_viol_seq_i | input | LANES*SEQ_W | Violator sequence number |
| redir_valid_o | output | 1 | Squash and fetch redirect request |
| redir_seq_o | output | SEQ_W | Squash sequence number |
| redir_cause_o | output | 1 | 0 branch, 1 memory order |
| iq_viol_valid_o | output | 1 | Violating pair notification |
| iq_viol_inst_seq_o | output | SEQ_W | Executing instruction of the pair |
| iq_viol_src_seq_o | output | SEQ_W | Violator of the pair |
| stat_misp_taken_o | output | CNT_W | Acted mispredicts predicted taken |
| stat_misp_ntaken_o | output | CNT_W | Acted mispredicts predicted not taken |
| stat_viol_ignored_o | output | CNT_W | Violations counted but not acted upon |

## Verification
Two functions meet in one group when a mispredict and a memory-order violation arrive in the same cycle. They can be on one lane or on different lanes with ordered or equal sequence numbers. In that case the priority on a lane and the oldest-wins replacement across lanes both decide the result. The bench provokes this with directed groups and then with a long run of random groups. The random groups draw sequence numbers from a narrow range, so ties and reversals are common. Every registered output is compared each cycle against a behavioural lane walk that the bench computes from the requirements.

// File: rtl/squash_pick_pkg.sv
`timescale 1ns/1ps
package squash_pick_pkg;
  typedef enum logic [0:0] {
    CAUSE_BRANCH = 1'b0,
    CAUSE_MEMORD = 1'b1
  } cause_e;
endpackage

// File: rtl/squash_pick_step.sv
`timescale 1ns/1ps
// One link of the in-order lane walk: decides whether this lane claims the squash.
module squash_pick_step
  import squash_pick_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             in_pend,
  input  logic [SEQ_W-1:0] in_seq,
  input  cause_e           in_cause,
  input  logic [SEQ_W-1:0] in_pair,
  input  logic             ln_valid,
  input  logic [SEQ_W-1:0] ln_seq,
  input  logic             ln_misp,
  input  logic             ln_pred_taken,
  input  logic             ln_load,
  input  logic             ln_done,
  input  logic             ln_viol,
  input  logic [SEQ_W-1:0] ln_vseq,
  output logic             out_pend,
  output logic [SEQ_W-1:0] out_seq,
  output cause_e           out_cause,
  output logic [SEQ_W-1:0] out_pair,
  output logic             hit_taken,
  output logic             hit_ntaken,
  output logic             hit_ignored
);
  logic may_claim;
  logic load_hold;
  logic take_br;
  logic take_mo;

  always_comb begin
    may_claim = ln_valid && (!in_pend || (ln_seq < in_seq));
    load_hold = ln_load && !ln_done;
    take_br   = may_claim && ln_misp && !load_hold;
    take_mo   = may_claim && !take_br && ln_viol;

    out_pend  = in_pend;
    out_seq   = in_seq;
    out_cause = in_cause;
    out_pair  = in_pair;
    if (take_br) begin
      out_pend  = 1'b1;
      out_seq   = ln_seq;
      out_cause = CAUSE_BRANCH;
    end else if (take_mo) begin
      out_pend  = 1'b1;
      out_seq   = ln_vseq;
      out_cause = CAUSE_MEMORD;
      out_pair  = ln_seq;
    end

    hit_taken   = take_br && ln_pred_taken;
    hit_ntaken  = take_br && !ln_pred_taken;
    hit_ignored = ln_valid && !may_claim && ln_viol;
  end
endmodule

// File: rtl/squash_pick_tally.sv
`timescale 1ns/1ps
// Population count of a per-lane hit vector.
module squash_pick_tally #(
  parameter int N     = 4,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     hits,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CNT_W'(hits[i]);
    end
  end
endmodule

// File: rtl/squash_pick.sv
`timescale 1ns/1ps
module squash_pick
  import squash_pick_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEQ_W = 16,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            lane_valid_i,
  input  logic [LANES-1:0][SEQ_W-1:0] lane_seq_i,
  input  logic [LANES-1:0]            lane_misp_i,
  input  logic [LANES-1:0]            lane_pred_taken_i,
  input  logic [LANES-1:0]            lane_load_i,
  input  logic [LANES-1:0]            lane_done_i,
  input  logic [LANES-1:0]            lane_viol_i,
  input  logic [LANES-1:0][SEQ_W-1:0] lane_viol_seq_i,
  output logic                        redir_valid_o,
  output logic [SEQ_W-1:0]            redir_seq_o,
  output logic                        redir_cause_o,
  output logic                        iq_viol_valid_o,
  output logic [SEQ_W-1:0]            iq_viol_inst_seq_o,
  output logic [SEQ_W-1:0]            iq_viol_src_seq_o,
  output logic [CNT_W-1:0]            stat_misp_taken_o,
  output logic [CNT_W-1:0]            stat_misp_ntaken_o,
  output logic [CNT_W-1:0]            stat_viol_ignored_o
);
  // walk chain, index 0 is the cleared start-of-group state
  logic [LANES:0]            ch_pend;
  logic [LANES:0][SEQ_W-1:0] ch_seq;
  logic [LANES:0][SEQ_W-1:0] ch_pair;
  cause_e                    ch_cause [LANES+1];
  logic [LANES-1:0]          hit_t, hit_n, hit_i;

  assign ch_pend[0]  = 1'b0;
  assign ch_seq[0]   = '0;
  assign ch_pair[0]  = '0;
  assign ch_cause[0] = CAUSE_BRANCH;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    squash_pick_step #(.SEQ_W(SEQ_W)) step_i (
      .in_pend       (ch_pend[g]),
      .in_seq        (ch_seq[g]),
      .in_cause      (ch_cause[g]),
      .in_pair       (ch_pair[g]),
      .ln_valid      (lane_valid_i[g]),
      .ln_seq        (lane_seq_i[g]),
      .ln_misp       (lane_misp_i[g]),
      .ln_pred_taken (lane_pred_taken_i[g]),
      .ln_load       (lane_load_i[g]),
      .ln_done       (lane_done_i[g]),
      .ln_viol       (lane_viol_i[g]),
      .ln_vseq       (lane_viol_seq_i[g]),
      .out_pend      (ch_pend[g+1]),
      .out_seq       (ch_seq[g+1]),
      .out_cause     (ch_cause[g+1]),
      .out_pair      (ch_pair[g+1]),
      .hit_taken     (hit_t[g]),
      .hit_ntaken    (hit_n[g]),
      .hit_ignored   (hit_i[g])
    );
  end

  logic [CNT_W-1:0] cnt_t, cnt_n, cnt_i;

  squash_pick_tally #(.N(LANES), .CNT_W(CNT_W)) tally_t_i (.hits(hit_t), .count(cnt_t));
  squash_pick_tally #(.N(LANES), .CNT_W(CNT_W)) tally_n_i (.hits(hit_n), .count(cnt_n));
  squash_pick_tally #(.N(LANES), .CNT_W(CNT_W)) tally_i_i (.hits(hit_i), .count(cnt_i));

  // next-state
  logic             nx_valid, nx_cause, nx_iqv;
  logic [SEQ_W-1:0] nx_seq, nx_iq_inst, nx_iq_src;

  always_comb begin
    nx_valid   = ch_pend[LANES];
    nx_seq     = ch_pend[LANES] ? ch_seq[LANES] : '0;
    nx_cause   = ch_pend[LANES] && (ch_cause[LANES] == CAUSE_MEMORD);
    nx_iqv     = nx_cause;
    nx_iq_inst = nx_iqv ? ch_pair[LANES] : '0;
    nx_iq_src  = nx_iqv ? ch_seq[LANES] : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid_o       <= 1'b0;
      redir_seq_o         <= '0;
      redir_cause_o       <= 1'b0;
      iq_viol_valid_o     <= 1'b0;
      iq_viol_inst_seq_o  <= '0;
      iq_viol_src_seq_o   <= '0;
      stat_misp_taken_o   <= '0;
      stat_misp_ntaken_o  <= '0;
      stat_viol_ignored_o <= '0;
    end else begin
      redir_valid_o       <= nx_valid;
      redir_seq_o         <= nx_seq;
      redir_cause_o       <= nx_cause;
      iq_viol_valid_o     <= nx_iqv;
      iq_viol_inst_seq_o  <= nx_iq_inst;
      iq_viol_src_seq_o   <= nx_iq_src;
      stat_misp_taken_o   <= cnt_t;
      stat_misp_ntaken_o  <= cnt_n;
      stat_viol_ignored_o <= cnt_i;
    end
  end

  // R2
  idle_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid_i == '0) |=> (!redir_valid_o && stat_misp_taken_o == '0 &&
                              stat_misp_ntaken_o == '0 && stat_viol_ignored_o == '0));

  // R6
  iq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_viol_valid_o |-> (redir_valid_o && redir_cause_o && redir_seq_o == iq_viol_src_seq_o));

  // R9
  misp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_misp_taken_o != '0 || stat_misp_ntaken_o != '0) |-> redir_valid_o);

  // R8
  ignored_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_viol_ignored_o != '0) |-> (redir_valid_o && stat_viol_ignored_o < CNT_W'(LANES)));

  // R10
  lane0_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid_i[0] && lane_misp_i[0] && !lane_load_i[0]) |=> redir_valid_o);
endmodule

// File: tb/squash_pick_tb.sv
`timescale 1ns/1ps
module squash_pick_tb_top;
  localparam int LANES = 4;
  localparam int SEQ_W = 16;
  localparam int CNT_W = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;  // 125 MHz

  logic [LANES-1:0]            v, mp, pt, ld, ex, vl;
  logic [LANES-1:0][SEQ_W-1:0] sq, vs;

  logic             r_valid, r_cause, iq_v;
  logic [SEQ_W-1:0] r_seq, iq_inst, iq_src;
  logic [CNT_W-1:0] c_t, c_n, c_i;

  squash_pick #(.LANES(LANES), .SEQ_W(SEQ_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lane_valid_i(v), .lane_seq_i(sq), .lane_misp_i(mp), .lane_pred_taken_i(pt),
    .lane_load_i(ld), .lane_done_i(ex), .lane_viol_i(vl), .lane_viol_seq_i(vs),
    .redir_valid_o(r_valid), .redir_seq_o(r_seq), .redir_cause_o(r_cause),
    .iq_viol_valid_o(iq_v), .iq_viol_inst_seq_o(iq_inst), .iq_viol_src_seq_o(iq_src),
    .stat_misp_taken_o(c_t), .stat_misp_ntaken_o(c_n), .stat_viol_ignored_o(c_i)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int e_valid, e_seq, e_cause, e_iqv, e_iqi, e_iqs, e_t, e_n, e_i;

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "redir_valid", int'(r_valid), e_valid);
    cmp(req, "redir_seq", int'(r_seq), e_seq);
    cmp(req, "redir_cause", int'(r_cause), e_cause);
    cmp(req, "iq_valid", int'(iq_v), e_iqv);
    cmp(req, "iq_inst", int'(iq_inst), e_iqi);
    cmp(req, "iq_src", int'(iq_src), e_iqs);
    cmp(req, "cnt_taken", int'(c_t), e_t);
    cmp(req, "cnt_ntaken", int'(c_n), e_n);
    cmp(req, "cnt_ignored", int'(c_i), e_i);
  endtask

  // behavioural walk of one group, straight from the requirements
  task automatic model();
    bit pend = 0;
    int pseq = 0, cause = 0, pair = 0, nt = 0, nn = 0, ni = 0;
    for (int i = 0; i < LANES; i++) begin
      bit elig;
      if (v[i]) begin
        elig = !pend || (int'(sq[i]) < pseq);
        if (!elig) begin
          if (vl[i]) ni++;
        end else if (mp[i] && !(ld[i] && !ex[i])) begin
          pend = 1; pseq = int'(sq[i]); cause = 0;
          if (pt[i]) nt++; else nn++;
        end else if (vl[i]) begin
          pend = 1; pseq = int'(vs[i]); cause = 1; pair = int'(sq[i]);
        end
      end
    end
    e_valid = pend;
    e_seq   = pend ? pseq : 0;
    e_cause = pend ? cause : 0;
    e_iqv   = (pend && cause == 1) ? 1 : 0;
    e_iqi   = e_iqv ? pair : 0;
    e_iqs   = e_iqv ? pseq : 0;
    e_t = nt; e_n = nn; e_i = ni;
  endtask

  task automatic clear_lanes();
    v = '0; mp = '0; pt = '0; ld = '0; ex = '0; vl = '0; sq = '0; vs = '0;
  endtask

  task automatic set_lane(int l, int s, bit m, bit p, bit isld, bit dn, bit vi, int vsq);
    v[l] = 1'b1; sq[l] = SEQ_W'(s); mp[l] = m; pt[l] = p;
    ld[l] = isld; ex[l] = dn; vl[l] = vi; vs[l] = SEQ_W'(vsq);
  endtask

  // inputs already applied at this negedge; result appears after the next posedge
  task automatic run_group(string req);
    model();
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    clear_lanes();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    e_valid = 0; e_seq = 0; e_cause = 0; e_iqv = 0; e_iqi = 0; e_iqs = 0; e_t = 0; e_n = 0; e_i = 0;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: empty group
    clear_lanes(); run_group("R2");
    // R3: single mispredict, predicted taken
    clear_lanes(); set_lane(2, 40, 1, 1, 0, 1, 0, 0); run_group("R3");
    // R2: state does not carry into an empty group
    clear_lanes(); run_group("R2");
    // R9: not-taken prediction counted separately
    clear_lanes(); set_lane(1, 7, 1, 0, 0, 1, 0, 0); run_group("R9");
    // R4: unexecuted load mispredict blocked, executed one accepted
    clear_lanes(); set_lane(0, 11, 1, 1, 1, 0, 0, 0); run_group("R4");
    clear_lanes(); set_lane(0, 11, 1, 1, 1, 1, 0, 0); run_group("R4");
    // R4: blocked mispredict still lets its violation through
    clear_lanes(); set_lane(3, 14, 1, 0, 1, 0, 1, 19); run_group("R4");
    // R5: both on one lane, branch wins
    clear_lanes(); set_lane(1, 22, 1, 0, 0, 1, 1, 30); run_group("R5");
    // R6: violation squashes from violator
    clear_lanes(); set_lane(0, 10, 0, 0, 1, 1, 1, 12); run_group("R6");
    // R7: equal sequence does not replace; older does
    clear_lanes(); set_lane(0, 20, 1, 1, 0, 1, 0, 0); set_lane(1, 20, 1, 0, 0, 1, 0, 0); run_group("R7");
    clear_lanes(); set_lane(0, 30, 1, 1, 0, 1, 0, 0); set_lane(2, 25, 1, 0, 0, 1, 0, 0); run_group("R7");
    clear_lanes(); set_lane(0, 50, 0, 0, 0, 1, 1, 60); set_lane(1, 45, 1, 1, 0, 1, 0, 0); run_group("R7");
    // R8: violation on a lane that may not claim
    clear_lanes(); set_lane(0, 5, 1, 1, 0, 1, 0, 0); set_lane(1, 9, 0, 0, 1, 1, 1, 3); run_group("R8");
    // R10: invalid lane ignored
    clear_lanes(); set_lane(2, 8, 1, 1, 0, 1, 1, 2); v[2] = 1'b0; run_group("R10");
    clear_lanes(); set_lane(0, 40, 1, 1, 0, 1, 0, 0); set_lane(1, 4, 1, 0, 0, 1, 1, 1); v[1] = 1'b0;
    run_group("R10");

    // random groups with a narrow sequence range: mixes R3 to R10
    for (int n = 0; n < 3000; n++) begin
      clear_lanes();
      for (int l = 0; l < LANES; l++) begin
        v[l]  = ($urandom_range(0, 3) != 0);
        sq[l] = SEQ_W'($urandom_range(0, 15));
        mp[l] = ($urandom_range(0, 2) == 0);
        pt[l] = $urandom_range(0, 1);
        ld[l] = $urandom_range(0, 1);
        ex[l] = $urandom_range(0, 1);
        vl[l] = ($urandom_range(0, 2) == 0);
        vs[l] = SEQ_W'($urandom_range(0, 15));
      end
      if (n % 500 == 499) begin
        sq[0] = '1; vs[0] = '1;  // top of the unsigned range
      end
      run_group("R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule